// File: doc/BRIEF.md
# Staged Configuration Register Bank

This block is a bank of memory-mapped configuration registers on a simple 32-bit bus. The bus has an address, write data, read data, and one write strobe and one read strobe. Each functional area of the chip gets its own 1 KiB address window. Software writes configuration fields into staged (shadow) copies, and those writes do not yet reach the logic that uses the fields. A single commit write then moves every staged value into the live outputs on one clock edge. The downstream logic therefore never sees a mix of old and new settings.

Each register also answers at two more addresses. One ORs ones into the staged copy and the other clears bits in it, so a field can be changed without a read-modify-write cycle. A separate address reads back the live value, so software can compare what it staged with what is applied. A fixed identity word at the start of the first window lets software confirm which firmware it is talking to. Bits that no field uses are dropped on write and read as zero.

Top module: `ctrl_shadow_bank`

## Requirements
- R1: On synchronous reset, the staged and live copies of each register take their reset values, and `rdata` goes to zero. The reset values are register 0 = 0x00000003, register 1 = 0x00000000, register 2 = 0x000000A5 and register 3 = 0x00000000.
- R2: A read of address 0x000 returns the identity constant 0x5EC01D01. Writes to that address change nothing.
- R3: Register k sits in window k/2 at offset 4*(k%2+1), which gives 0x004, 0x008, 0x404 and 0x408. A write there stores wdata AND mask into the staged copy, and a read there returns the staged copy. The masks are 0x001F01FF, 0x800000FF, 0x0000FFFF and 0x0F0F0F0F. Unassigned bits read as zero.
- R4: A write at base+0x100 ORs (wdata AND mask) into the staged copy. A write at base+0x200 clears the staged bits where wdata is one. Reads at these two alias addresses return zero.
- R5: The live outputs `act_o` change only on the clock edge of a commit write. `act_o` carries register k in bits [32k+31:32k].
- R6: A write with bit 0 set to offset 0x3FC of any mapped window (0x3FC or 0x7FC) copies every staged register into its live copy on that edge. With bit 0 clear, the same write does nothing. That address reads as zero.
- R7: A read at base+0x300 returns the live copy of the register.
- R8: Reads of unmapped addresses return zero, and writes to them have no effect. Unmapped addresses are window indices 2 and 3, unused words, addresses with nonzero bits [1:0], and offset 0x000 of window 1.
- R9: `rdata` is registered. It shows the selected value in the cycle after the read strobe and holds it until the next read strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | 12 | Byte address |
| wdata | input | 32 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rdata | output | 32 | Registered read data |
| act_o | output | 128 | Live register values, register k in bits [32k+31:32k] |

## Verification
Every register is written with all-ones, all-zeros, two alternating checkerboards and a walking single one across all 32 bits. The walking one shows, bit by bit, which positions the mask keeps. Set and clear aliases are applied over known staged contents, which separates an OR or AND-NOT update from a plain overwrite. Commit is tried with bit 0 clear, then through each window in turn, with the live outputs read before and after to show whether staging leaks early or the copy is incomplete. Unmapped, misaligned and out-of-window accesses are interleaved with mapped ones so that any stray decode shows up in later reads.

// File: rtl/ctrl_shadow_bank.sv
module ctrl_shadow_bank #(
  parameter int NWIN = 2,
  parameter int RPW = 2,
  parameter int ADDR_W = 12,
  parameter logic [31:0] ID_VALUE = 32'h5EC0_1D01,
  parameter logic [NWIN*RPW*32-1:0] FIELD_MASK =
    {32'h0F0F_0F0F, 32'h0000_FFFF, 32'h8000_00FF, 32'h001F_01FF},
  parameter logic [NWIN*RPW*32-1:0] RESET_VAL =
    {32'h0000_0000, 32'h0000_00A5, 32'h0000_0000, 32'h0000_0003}
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [31:0]              wdata,
  input  logic                     wr_en,
  input  logic                     rd_en,
  output logic [31:0]              rdata,
  output logic [NWIN*RPW*32-1:0]   act_o
);
  localparam int NREG = NWIN * RPW;

  logic [31:0]        win;
  logic [9:0]         off;
  logic [5:0]         word;
  logic [1:0]         kind;
  logic               win_ok, aligned, commit;
  logic [NREG*32-1:0] shd_flat;
  logic [31:0]        rd_val;

  assign win     = 32'(addr[ADDR_W-1:10]);
  assign off     = addr[9:0];
  assign kind    = off[9:8];
  assign word    = off[7:2];
  assign aligned = (off[1:0] == 2'b00);
  assign win_ok  = (win < NWIN);
  assign commit  = wr_en && win_ok && (off == 10'h3FC) && wdata[0];

  for (genvar k = 0; k < NREG; k++) begin : g_reg
    localparam logic [31:0] M  = FIELD_MASK[k*32 +: 32];
    localparam logic [31:0] RV = RESET_VAL[k*32 +: 32] & M;
    logic        hit;
    logic [31:0] shd, act, nxt;

    assign hit = wr_en && win_ok && aligned &&
                 (win == 32'(k / RPW)) && (word == 6'(k % RPW + 1));

    always_comb begin
      nxt = shd;
      if (hit) begin
        case (kind)
          2'd0:    nxt = wdata & M;
          2'd1:    nxt = shd | (wdata & M);
          2'd2:    nxt = shd & ~(wdata & M);
          default: nxt = shd;
        endcase
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        shd <= RV;
        act <= RV;
      end else begin
        shd <= nxt;
        if (commit) act <= nxt;
      end
    end

    assign shd_flat[k*32 +: 32] = shd;
    assign act_o[k*32 +: 32]    = act;
  end

  always_comb begin
    rd_val = '0;
    if (win_ok && aligned) begin
      if (win == 0 && off == 10'h000) rd_val = ID_VALUE;
      for (int k = 0; k < NREG; k++) begin
        if (win == 32'(k / RPW) && word == 6'(k % RPW + 1)) begin
          if (kind == 2'd0)      rd_val = shd_flat[k*32 +: 32];
          else if (kind == 2'd3) rd_val = act_o[k*32 +: 32];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_val;
  end
endmodule

// File: rtl/ctrl_shadow_bank_chk.sv
module ctrl_shadow_bank_chk #(
  parameter int NWIN = 2,
  parameter int RPW = 2,
  parameter int ADDR_W = 12,
  parameter logic [31:0] ID_VALUE = 32'h5EC0_1D01
) (
  input logic                   clk,
  input logic                   rst,
  input logic [ADDR_W-1:0]      addr,
  input logic [31:0]            wdata,
  input logic                   wr_en,
  input logic                   rd_en,
  input logic [31:0]            rdata,
  input logic [NWIN*RPW*32-1:0] act_o,
  input logic [NWIN*RPW*32-1:0] shd
);
  logic commit_w, out_win;
  assign commit_w = wr_en && (32'(addr[ADDR_W-1:10]) < NWIN) &&
                    (addr[9:0] == 10'h3FC) && wdata[0];
  assign out_win  = 32'(addr[ADDR_W-1:10]) >= NWIN;

  // R6
  commit_copy_chk: assert property (@(posedge clk) disable iff (rst)
    commit_w |=> (act_o == shd));

  // R5
  live_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !commit_w |=> $stable(act_o));

  // R9
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));

  // R2
  id_read_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == '0) |=> (rdata == ID_VALUE));

  // R8
  unmapped_read_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && out_win) |=> (rdata == 32'h0));
endmodule

bind ctrl_shadow_bank ctrl_shadow_bank_chk #(
  .NWIN(NWIN), .RPW(RPW), .ADDR_W(ADDR_W), .ID_VALUE(ID_VALUE)
) u_chk (
  .clk(clk), .rst(rst), .addr(addr), .wdata(wdata), .wr_en(wr_en),
  .rd_en(rd_en), .rdata(rdata), .act_o(act_o), .shd(shd_flat)
);

// File: tb/ctrl_shadow_bank_tb.sv
module ctrl_shadow_bank_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] ID = 32'h5EC0_1D01;
  localparam logic [31:0] MASK [4] = '{32'h001F_01FF, 32'h8000_00FF, 32'h0000_FFFF, 32'h0F0F_0F0F};
  localparam logic [31:0] RSTV [4] = '{32'h0000_0003, 32'h0, 32'h0000_00A5, 32'h0};

  logic         clk = 0, rst = 1, wr_en = 0, rd_en = 0;
  logic [11:0]  addr = '0;
  logic [31:0]  wdata = '0, rdata;
  logic [127:0] act_o;
  logic [31:0]  sh [4], ac [4];
  logic [31:0]  q;
  int errors = 0, checks = 0;
  bit done = 0;

  ctrl_shadow_bank u_dut (.clk(clk), .rst(rst), .addr(addr), .wdata(wdata),
    .wr_en(wr_en), .rd_en(rd_en), .rdata(rdata), .act_o(act_o));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [11:0] base(input int k);
    return 12'((k / 2) * 'h400 + (k % 2 + 1) * 4);
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] r);
    @(negedge clk); addr = a; rd_en = 1;
    @(negedge clk); rd_en = 0; r = rdata;
  endtask

  task automatic rd_chk(input string tag, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] r;
    rd(a, r);
    chk(tag, r, exp);
  endtask

  task automatic chk_live(input string tag);
    for (int k = 0; k < 4; k++) chk(tag, act_o[k*32 +: 32], ac[k]);
  endtask

  task automatic commit_all();
    for (int k = 0; k < 4; k++) ac[k] = sh[k];
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: run did not complete, got hung expected done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] pats [4];
    pats = '{32'hFFFF_FFFF, 32'h0, 32'hA5A5_A5A5, 32'h5A5A_5A5A};
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    for (int k = 0; k < 4; k++) begin sh[k] = RSTV[k]; ac[k] = RSTV[k]; end
    // R1 reset state
    chk("R1 rdata", rdata, 32'h0);
    chk_live("R1 live");
    for (int k = 0; k < 4; k++) rd_chk("R1 staged", base(k), RSTV[k]);

    // R2 identity word and write immunity
    rd_chk("R2 id", 12'h000, ID);
    wr(12'h000, 32'h1234_5678);
    rd_chk("R2 id after write", 12'h000, ID);
    chk_live("R2 live");

    // R3 and R5: pattern sweep on staged copies
    for (int k = 0; k < 4; k++) begin
      for (int p = 0; p < 4; p++) begin
        wr(base(k), pats[p]); sh[k] = pats[p] & MASK[k];
        rd_chk("R3 pattern", base(k), sh[k]);
      end
      for (int b = 0; b < 32; b++) begin
        wr(base(k), 32'h1 << b); sh[k] = (32'h1 << b) & MASK[k];
        rd_chk("R3 walk", base(k), sh[k]);
      end
      chk_live("R5 no leak");
    end

    // R4 set and clear aliases
    for (int k = 0; k < 4; k++) begin
      wr(base(k), 32'h0); sh[k] = 0;
      wr(base(k) + 12'h100, 32'hF0F0_3C3C); sh[k] = sh[k] | (32'hF0F0_3C3C & MASK[k]);
      rd_chk("R4 set", base(k), sh[k]);
      wr(base(k) + 12'h100, 32'h0000_0101); sh[k] = sh[k] | (32'h0000_0101 & MASK[k]);
      rd_chk("R4 set or", base(k), sh[k]);
      wr(base(k) + 12'h200, 32'h3030_0C01); sh[k] = sh[k] & ~32'h3030_0C01;
      rd_chk("R4 clear", base(k), sh[k]);
      rd_chk("R4 alias read", base(k) + 12'h100, 32'h0);
      rd_chk("R4 alias read", base(k) + 12'h200, 32'h0);
    end
    chk_live("R5 after alias");

    // R6 and R7 commit
    for (int k = 0; k < 4; k++) begin
      wr(base(k), 32'h1111_1111 * (k + 3)); sh[k] = (32'h1111_1111 * (k + 3)) & MASK[k];
    end
    wr(12'h3FC, 32'h0000_0002);
    chk_live("R6 bit0 clear");
    for (int k = 0; k < 4; k++) rd_chk("R7 live before", base(k) + 12'h300, ac[k]);
    wr(12'h7FC, 32'h1); commit_all();
    chk_live("R6 commit win1");
    rd_chk("R6 commit reads zero", 12'h7FC, 32'h0);
    rd_chk("R6 commit reads zero", 12'h3FC, 32'h0);
    for (int k = 0; k < 4; k++) begin
      wr(base(k) + 12'h200, 32'hFFFF_FFFF); sh[k] = 0;
      rd_chk("R7 live after stage", base(k) + 12'h300, ac[k]);
    end
    chk_live("R5 held");
    wr(12'h3FC, 32'hFFFF_FFFF); commit_all();
    chk_live("R6 commit win0");

    // R8 unmapped
    wr(12'h00C, 32'hFFFF_FFFF);
    wr(12'h806, 32'hFFFF_FFFF);
    wr(12'hC04, 32'hFFFF_FFFF);
    wr(12'h005, 32'hFFFF_FFFF);
    wr(12'hBFC, 32'h1);
    for (int k = 0; k < 4; k++) rd_chk("R8 no side effect", base(k), sh[k]);
    chk_live("R8 no commit");
    rd_chk("R8 unused word", 12'h00C, 32'h0);
    rd_chk("R8 window2", 12'h804, 32'h0);
    rd_chk("R8 window3", 12'hC08, 32'h0);
    rd_chk("R8 misaligned", 12'h006, 32'h0);
    rd_chk("R8 win1 zero", 12'h400, 32'h0);

    // R9 latency and hold
    wr(base(0), 32'h0000_0055); sh[0] = 32'h55;
    @(negedge clk); addr = base(0); rd_en = 1;
    chk("R9 not yet", rdata, 32'h0);
    @(negedge clk); rd_en = 0; addr = 12'h000;
    chk("R9 one cycle", rdata, 32'h55);
    repeat (3) @(negedge clk);
    chk("R9 hold", rdata, 32'h55);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule